// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Segment Driver

This block turns a serial pixel stream from a dot-matrix display controller into 80 segment drive codes. The segments are split into two independent 40-bit halves. Half A serves segments 1 to 40 and half B serves segments 41 to 80. Each half has its own shift register, and a direction input sets which way that register moves. The two serial data pins of a half swap between input and output with the direction. The bit that leaves the far end of the register therefore appears on the output pin, ready to feed the next device in a chain.

The shift clock and the latch clock arrive asynchronously. Each is passed through a synchroniser into the system clock domain and acts on its falling edge. A latch edge copies both shift registers into holding latches, and only those latches drive the segments. A frame-alternation input combines with each latched bit to choose one of four drive levels. The analog level switch downstream decodes that level as a 2-bit code per segment.

Top module: `serial_seg_driver`

## Requirements
- R1: While reset is held low at a clock edge, both shift registers and both latches clear to zero. After reset every segment code is 2'b10 with alt_m low and 2'b11 with alt_m high, and every enabled serial output drives 0.
- R2: A shift register moves only on a falling edge of shift_clk, and it moves by exactly one position. The move takes effect at the third rising clk edge after the pin falls: two synchroniser stages, then the edge register. Rising edges and steady levels have no effect.
- R3: With a half's direction input low, data enters at its left pin. It enters at the half's lowest-numbered segment and moves toward the highest-numbered one. The right pin is the output (right_oe=1, left_oe=0).
- R4: With a half's direction input high, data enters at its right pin. It enters at the highest-numbered segment and moves toward the lowest-numbered one. The left pin is the output (left_oe=1, right_oe=0).
- R5: The enabled serial output carries the bit that sits at the far end of the register, which is the bit the next shift pushes out. A pin that is not enabled drives 0.
- R6: A falling edge of latch_clk copies both complete shift registers into the latches, on the same three-edge timing as R2. Segment codes depend only on the latches, so shifting alone never changes them.
- R7: The code of segment k sits at seg_code[2k-1:2k-2]. A latched 1 gives 2'b00 when alt_m=1 and 2'b01 when alt_m=0. A latched 0 gives 2'b10 when alt_m=0 and 2'b11 when alt_m=1. The code follows alt_m with no clock delay.
- R8: The two halves use their own direction inputs independently. The data pin that the direction does not select as the input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Asynchronous shift clock, acts on falling edge |
| latch_clk | input | 1 | Asynchronous latch clock, acts on falling edge |
| alt_m | input | 1 | Frame alternation (drive polarity) |
| dir_a | input | 1 | Shift direction of half A |
| dir_b | input | 1 | Shift direction of half B |
| a_left_i | input | 1 | Half A left data pin, input side |
| a_left_o | output | 1 | Half A left data pin, output side |
| a_left_oe | output | 1 | Half A left data pin, output enable |
| a_right_i | input | 1 | Half A right data pin, input side |
| a_right_o | output | 1 | Half A right data pin, output side |
| a_right_oe | output | 1 | Half A right data pin, output enable |
| b_left_i | input | 1 | Half B left data pin, input side |
| b_left_o | output | 1 | Half B left data pin, output side |
| b_left_oe | output | 1 | Half B left data pin, output enable |
| b_right_i | input | 1 | Half B right data pin, input side |
| b_right_o | output | 1 | Half B right data pin, output side |
| b_right_oe | output | 1 | Half B right data pin, output enable |
| seg_code | output | 160 | 2-bit drive code per segment, segment 1 in bits 1:0 |

## Verification
The hardest situation to reach from the ports is the cascade output. A bit only appears on the far-end pin after it has crossed all 40 positions, and each crossing needs a full synchronised clock pulse. The stimulus therefore shifts complete 40-bit patterns into both halves, with opposite directions on the two halves. It then swaps both directions and shifts fresh patterns. On every shift it drives the unselected data pin with the inverse of the wanted bit, so any wrong input choice corrupts the latched image.

// File: rtl/seg_drv_pkg.sv
// Package: shared drive-level encoding for the segment driver.
// Assumes: consumers decode the 2-bit code as listed in drive_lvl_e.
package seg_drv_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        LVL_SEL_MHI = 2'b00,   // selected segment, alternation high
        LVL_SEL_MLO = 2'b01,   // selected segment, alternation low
        LVL_OFF_MLO = 2'b10,   // unselected segment, alternation low
        LVL_OFF_MHI = 2'b11    // unselected segment, alternation high
    } drive_lvl_e;

    // Map one latched pixel and the alternation phase to its drive level.
    function automatic drive_lvl_e level_of(input logic on, input logic m);
        if (on) return m ? LVL_SEL_MHI : LVL_SEL_MLO;
        else    return m ? LVL_OFF_MHI : LVL_OFF_MLO;
    endfunction

endpackage

// File: rtl/seg_pin_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes: every bit is held longer than STAGES clk periods around its change,
// so bits that move together are also seen together.
module seg_pin_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift raw pin values through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/seg_fall_det.sv
// Falling-edge detector on already synchronised signals.
// Assumes: input is in the clk domain; output is a one-cycle pulse.
module seg_fall_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    // Remember the previous synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    assign fall = prev & ~cur;
endmodule

// File: rtl/seg_shift_half.sv
// One bidirectional shift register half with its two serial pins.
// dir=0: enter at left into index 0, move upward, right pin outputs index W-1.
// dir=1: enter at right into index W-1, move downward, left pin outputs index 0.
// Assumes: step is a one-cycle pulse; data inputs are synchronised.
module seg_shift_half #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         dir,
    input  logic         left_i,
    input  logic         right_i,
    output logic         left_o,
    output logic         left_oe,
    output logic         right_o,
    output logic         right_oe,
    output logic [W-1:0] sr_o
);
    logic [W-1:0] sr;

    // Advance the register one position in the selected direction.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (step) begin
            if (dir) sr <= {right_i, sr[W-1:1]};
            else     sr <= {sr[W-2:0], left_i};
        end
    end

    assign left_oe  = dir;
    assign right_oe = ~dir;
    assign left_o   = dir  & sr[0];
    assign right_o  = ~dir & sr[W-1];
    assign sr_o     = sr;
endmodule

// File: rtl/seg_level_encode.sv
// Holding latch for one half plus the per-segment drive-code encoder.
// Assumes: load is a one-cycle pulse; alt_m feeds the code without delay.
module seg_level_encode
    import seg_drv_pkg::*;
#(
    parameter int W = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [W-1:0]        din,
    input  logic                alt_m,
    output logic [W-1:0]        lat_o,
    output logic [CODE_W*W-1:0] code_o
);
    logic [W-1:0] lat;

    // Capture the whole shift register on a latch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    lat <= '0;
        else if (load) lat <= din;
    end

    for (genvar k = 0; k < W; k++) begin : g_seg
        assign code_o[CODE_W*k +: CODE_W] = level_of(lat[k], alt_m);
    end

    assign lat_o = lat;
endmodule

// File: rtl/serial_seg_driver.sv
// Top: two 40-bit bidirectional halves feeding 80 segment drive codes.
// Shift and latch clocks are synchronised to clk and act on falling edges;
// the data pins travel with them through the same synchroniser.
// Assumes: pins meet the external setup/hold windows, which exceed STAGES+1 clk.
module serial_seg_driver
    import seg_drv_pkg::*;
#(
    parameter int HALF_W      = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_clk,
    input  logic                        latch_clk,
    input  logic                        alt_m,
    input  logic                        dir_a,
    input  logic                        dir_b,
    input  logic                        a_left_i,
    output logic                        a_left_o,
    output logic                        a_left_oe,
    input  logic                        a_right_i,
    output logic                        a_right_o,
    output logic                        a_right_oe,
    input  logic                        b_left_i,
    output logic                        b_left_o,
    output logic                        b_left_oe,
    input  logic                        b_right_i,
    output logic                        b_right_o,
    output logic                        b_right_oe,
    output logic [CODE_W*2*HALF_W-1:0]  seg_code
);
    localparam int NHALF  = 2;
    localparam int NPIN   = 2 + 2 * NHALF;
    localparam int HCODEW = CODE_W * HALF_W;

    logic [NPIN-1:0]  pin_raw, pin_s;
    logic [1:0]       falls;
    logic             sh_fall, lt_fall;
    logic [NHALF-1:0] dir_v, lo_v, loe_v, ro_v, roe_v;
    logic [HALF_W-1:0] sr_q  [NHALF];
    logic [HALF_W-1:0] lat_q [NHALF];
    logic [HALF_W-1:0] sr_a, sr_b, lat_a, lat_b;

    assign pin_raw = {shift_clk, latch_clk, b_right_i, b_left_i, a_right_i, a_left_i};
    assign dir_v   = {dir_b, dir_a};

    seg_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
    );

    seg_fall_det #(.W(2)) u_fall (
        .clk(clk), .rst_n(rst_n), .cur(pin_s[NPIN-1 -: 2]), .fall(falls)
    );

    assign sh_fall = falls[1];
    assign lt_fall = falls[0];

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        seg_shift_half #(.W(HALF_W)) u_shift (
            .clk(clk), .rst_n(rst_n), .step(sh_fall), .dir(dir_v[h]),
            .left_i(pin_s[2*h]), .right_i(pin_s[2*h+1]),
            .left_o(lo_v[h]), .left_oe(loe_v[h]),
            .right_o(ro_v[h]), .right_oe(roe_v[h]),
            .sr_o(sr_q[h])
        );

        seg_level_encode #(.W(HALF_W)) u_enc (
            .clk(clk), .rst_n(rst_n), .load(lt_fall), .din(sr_q[h]),
            .alt_m(alt_m), .lat_o(lat_q[h]),
            .code_o(seg_code[h*HCODEW +: HCODEW])
        );
    end

    assign a_left_o   = lo_v[0];
    assign a_left_oe  = loe_v[0];
    assign a_right_o  = ro_v[0];
    assign a_right_oe = roe_v[0];
    assign b_left_o   = lo_v[1];
    assign b_left_oe  = loe_v[1];
    assign b_right_o  = ro_v[1];
    assign b_right_oe = roe_v[1];

    assign sr_a  = sr_q[0];
    assign sr_b  = sr_q[1];
    assign lat_a = lat_q[0];
    assign lat_b = lat_q[1];
endmodule

// File: rtl/seg_drv_chk.sv
// Checker for serial_seg_driver: temporal properties over ports and
// the shift/latch state, attached by bind below.
module seg_drv_chk #(
    parameter int HALF_W = 40
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  alt_m,
    input logic                  dir_a,
    input logic                  dir_b,
    input logic                  a_left_o,
    input logic                  a_left_oe,
    input logic                  a_right_o,
    input logic                  a_right_oe,
    input logic                  b_left_o,
    input logic                  b_left_oe,
    input logic                  b_right_o,
    input logic                  b_right_oe,
    input logic [4*HALF_W-1:0]   seg_code,
    input logic                  sh_fall,
    input logic                  lt_fall,
    input logic [HALF_W-1:0]     sr_a,
    input logic [HALF_W-1:0]     sr_b,
    input logic [HALF_W-1:0]     lat_a,
    input logic [HALF_W-1:0]     lat_b
);
    localparam int SEGS = 2 * HALF_W;
    logic [SEGS-1:0] hi_b, lo_b;

    for (genvar k = 0; k < SEGS; k++) begin : g_split
        assign hi_b[k] = seg_code[2*k+1];
        assign lo_b[k] = seg_code[2*k];
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (sr_a == '0 && sr_b == '0 && lat_a == '0 && lat_b == '0)); // R1

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_fall |=> ($stable(sr_a) && $stable(sr_b))); // R2

    AST_DIR_LOW_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_a |-> (a_right_oe && !a_left_oe && !a_left_o)); // R3

    AST_DIR_HIGH_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        dir_b |-> (b_left_oe && !b_right_oe && !b_right_o)); // R4

    AST_FAR_BIT_A: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_a |-> (a_right_o == sr_a[HALF_W-1])); // R5

    AST_FAR_BIT_B: assert property (@(posedge clk) disable iff (!rst_n)
        dir_b |-> (b_left_o == sr_b[0])); // R5

    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        lt_fall |=> (lat_a == $past(sr_a) && lat_b == $past(sr_b))); // R6

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lt_fall |=> ($stable(lat_a) && $stable(lat_b))); // R6

    AST_M_HIGH_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        alt_m |-> (hi_b == lo_b)); // R7

    AST_M_LOW_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_m |-> (hi_b == ~lo_b)); // R7

    AST_SEL_TRACKS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_b == ~{lat_b, lat_a})); // R7
endmodule

bind serial_seg_driver seg_drv_chk #(.HALF_W(HALF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alt_m(alt_m), .dir_a(dir_a), .dir_b(dir_b),
    .a_left_o(a_left_o), .a_left_oe(a_left_oe),
    .a_right_o(a_right_o), .a_right_oe(a_right_oe),
    .b_left_o(b_left_o), .b_left_oe(b_left_oe),
    .b_right_o(b_right_o), .b_right_oe(b_right_oe),
    .seg_code(seg_code), .sh_fall(sh_fall), .lt_fall(lt_fall),
    .sr_a(sr_a), .sr_b(sr_b), .lat_a(lat_a), .lat_b(lat_b)
);

// File: tb/sim_serial_seg_driver.sv
`timescale 1ns/1ps
module sim_serial_seg_driver;
    localparam int W   = 40;
    localparam int SW  = 4 * W;
    localparam int PER = 4;

    logic clk = 1'b0;
    always #(PER/2) clk = ~clk;

    logic rst_n, shift_clk, latch_clk, alt_m, dir_a, dir_b;
    logic a_left_i, a_right_i, b_left_i, b_right_i;
    logic a_left_o, a_left_oe, a_right_o, a_right_oe;
    logic b_left_o, b_left_oe, b_right_o, b_right_oe;
    logic [SW-1:0] seg_code;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    serial_seg_driver u0 (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .latch_clk(latch_clk),
        .alt_m(alt_m), .dir_a(dir_a), .dir_b(dir_b),
        .a_left_i(a_left_i), .a_left_o(a_left_o), .a_left_oe(a_left_oe),
        .a_right_i(a_right_i), .a_right_o(a_right_o), .a_right_oe(a_right_oe),
        .b_left_i(b_left_i), .b_left_o(b_left_o), .b_left_oe(b_left_oe),
        .b_right_i(b_right_i), .b_right_o(b_right_o), .b_right_oe(b_right_oe),
        .seg_code(seg_code)
    );

    // Reference model state: registers and latches per half, pin history queue.
    bit ma[W], mb[W], la[W], lb[W];
    logic [5:0] hq[$];

    function automatic logic [1:0] ecode(bit on, logic m);
        if (on) return m ? 2'b00 : 2'b01;   // R7 selected
        return m ? 2'b11 : 2'b10;           // R7 unselected
    endfunction

    function automatic bit pat(int i, int off);
        return (((i + off) * 5 + 1) % 3) == 0 || ((i + off) % 7 == 2);
    endfunction

    task automatic chk(string req, logic [SW-1:0] got, logic [SW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Behavioural model: an edge acts three rising clk edges after the pin moves (R2).
    always @(posedge clk) begin : model
        logic [5:0] old_s, new_s;
        if (!rst_n) begin
            hq = {6'd0, 6'd0, 6'd0, 6'd0};
            foreach (ma[k]) begin ma[k] = 0; mb[k] = 0; la[k] = 0; lb[k] = 0; end
        end else begin
            hq.push_back({shift_clk, latch_clk, b_right_i, b_left_i, a_right_i, a_left_i});
            void'(hq.pop_front());
            old_s = hq[0];
            new_s = hq[1];
            if (old_s[4] && !new_s[4]) begin la = ma; lb = mb; end
            if (old_s[5] && !new_s[5]) begin
                if (dir_a) begin
                    for (int k = 0; k < W-1; k++) ma[k] = ma[k+1];
                    ma[W-1] = new_s[1];
                end else begin
                    for (int k = W-1; k > 0; k--) ma[k] = ma[k-1];
                    ma[0] = new_s[0];
                end
                if (dir_b) begin
                    for (int k = 0; k < W-1; k++) mb[k] = mb[k+1];
                    mb[W-1] = new_s[3];
                end else begin
                    for (int k = W-1; k > 0; k--) mb[k] = mb[k-1];
                    mb[0] = new_s[2];
                end
            end
        end
    end

    // Per-clock comparison against the model, sampled 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (cmp_on) begin
            logic [SW-1:0] es;
            logic [7:0] ep, gp;
            for (int k = 0; k < W; k++) begin
                es[2*k +: 2]     = ecode(la[k], alt_m);
                es[2*(W+k) +: 2] = ecode(lb[k], alt_m);
            end
            chk("R2 R6 R7 per-clock segments", seg_code, es);
            ep = {dir_a, dir_a & ma[0], !dir_a, !dir_a & ma[W-1],
                  dir_b, dir_b & mb[0], !dir_b, !dir_b & mb[W-1]};
            gp = {a_left_oe, a_left_o, a_right_oe, a_right_o,
                  b_left_oe, b_left_o, b_right_oe, b_right_o};
            chk("R3 R4 R5 per-clock pins", SW'(gp), SW'(ep));
        end
    end

    task automatic smp();
        @(posedge clk);
        #1;
    endtask

    // One shift pulse; the unselected pin carries the inverse bit (R8).
    task automatic shift_pair(bit a, bit b);
        @(negedge clk);
        a_left_i  = dir_a ? ~a : a;
        a_right_i = dir_a ? a : ~a;
        b_left_i  = dir_b ? ~b : b;
        b_right_i = dir_b ? b : ~b;
        shift_clk = 1'b1;
        repeat (4) @(negedge clk);
        shift_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic latch_pulse();
        @(negedge clk);
        latch_clk = 1'b1;
        repeat (4) @(negedge clk);
        latch_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Expected image after 40 shifts of pat(i,off): dir low puts the first bit at the top.
    function automatic logic [2*W-1:0] half_img(bit dir, int off, logic m);
        logic [2*W-1:0] v;
        for (int k = 0; k < W; k++)
            v[2*k +: 2] = ecode(dir ? pat(k, off) : pat(W-1-k, off), m);
        return v;
    endfunction

    initial begin
        rst_n = 0; shift_clk = 0; latch_clk = 0; alt_m = 0; dir_a = 0; dir_b = 1;
        a_left_i = 0; a_right_i = 0; b_left_i = 0; b_right_i = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        smp();
        chk("R1 reset codes M=0", seg_code, {2*W{2'b10}});
        chk("R1 reset serial outs", SW'({a_left_o, a_right_o, b_left_o, b_right_o}), '0);
        @(negedge clk); alt_m = 1;
        smp();
        chk("R1 reset codes M=1", seg_code, {2*W{2'b11}});
        @(negedge clk); alt_m = 0;
        cmp_on = 1'b1;

        // Pass 1: half A low direction, half B high direction.
        for (int i = 0; i < W; i++) shift_pair(pat(i, 0), pat(i, 11));
        smp();
        chk("R6 shifting alone keeps codes", seg_code, {2*W{2'b10}});
        chk("R5 A cascade bit", SW'(a_right_o), SW'(pat(0, 0)));
        chk("R5 B cascade bit", SW'(b_left_o), SW'(pat(0, 11)));
        chk("R3 A pins enable", SW'({a_right_oe, a_left_oe}), SW'(2'b10));
        chk("R4 B pins enable", SW'({b_left_oe, b_right_oe}), SW'(2'b10));
        latch_pulse();
        smp();
        chk("R3 A image dir low", SW'(seg_code[0 +: 2*W]), SW'(half_img(0, 0, 0)));
        chk("R4 B image dir high", SW'(seg_code[2*W +: 2*W]), SW'(half_img(1, 11, 0)));
        @(negedge clk); alt_m = 1;
        smp();
        chk("R7 alternation flips codes", seg_code, {half_img(1, 11, 1), half_img(0, 0, 1)});

        // Pass 2: swap directions on both halves.
        @(negedge clk); dir_a = 1; dir_b = 0;
        smp();
        chk("R5 disabled pins low", SW'({a_right_o, b_left_o}), '0);
        for (int i = 0; i < W; i++) shift_pair(pat(i, 23), pat(i, 5));
        chk("R6 codes hold before latch", seg_code, {half_img(1, 11, 1), half_img(0, 0, 1)});
        latch_pulse();
        smp();
        chk("R4 A image dir high", SW'(seg_code[0 +: 2*W]), SW'(half_img(1, 23, 1)));
        chk("R3 B image dir low", SW'(seg_code[2*W +: 2*W]), SW'(half_img(0, 5, 1)));
        chk("R8 both halves independent", seg_code, {half_img(0, 5, 1), half_img(1, 23, 1)});

        // Pass 3: a few mixed shifts and a second latch at M=0.
        @(negedge clk); alt_m = 0; dir_a = 0;
        for (int i = 0; i < 5; i++) shift_pair(pat(i, 3), pat(i, 9));
        latch_pulse();
        repeat (10) smp();
        cmp_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * PER);
        fails++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule